// File: doc/BRIEF.md
# Interrupt Exception Entry and Return Sequencer

This block keeps the processor-state side of interrupt handling. When an interrupt is accepted, it copies the live program counter, status word and stack-pointer register into three shadow registers in a single clock. It latches the event code and forces the supervisor, alternate-bank and event-block bits of the status word. It then issues a one-cycle redirect to a handler address. That address is a programmable base plus a fixed offset of 0x600.

A return strobe puts back the saved program counter and status word through the same redirect outputs. The saved stack pointer stays in its shadow and is never written back.

The pipeline uses `redir_valid` to flush and refetch from `redir_pc`, and to load `sr_out` into its status register. Arbitration between interrupt sources and level masking are done before this block.

Top module: `irq_entry_seq`

## Requirements
- R1: After synchronous reset (`rst_n` low at a clock edge) the following outputs are all zero: `redir_valid`, `redir_pc`, `sr_out`, `evt_code`, `saved_r15` and `vec_base`.
- R2: An entry is accepted when `irq_req`=1 and `rte_strobe`=0, and either `live_sr` bit 28 is 0 or `irq_is_reset`=1. In the cycle after the edge, `redir_valid` is 1 and `redir_pc` equals `vec_base` plus 0x600.
- R3: On an accepted entry, `sr_out` equals `live_sr` with bits 30, 29 and 28 set to 1. Every other bit passes through unchanged, and for an ordinary interrupt that includes bit 15.
- R4: An entry with `irq_is_reset`=1 also clears `sr_out` bit 15. It is accepted even when `live_sr` bit 28 is 1.
- R5: On an accepted entry, `evt_code` bits 13..0 take `irq_code`, and bits 31..14 read as zero.
- R6: On an accepted entry, `saved_r15` takes `live_r15`. The saved program counter and saved status word take `live_pc` and `live_sr`.
- R7: When `live_sr` bit 28 is 1 and `irq_is_reset`=0, a request is ignored. No redirect is issued, and `evt_code` and `saved_r15` keep their values.
- R8: When `rte_strobe`=1, in the next cycle `redir_valid` is 1, `redir_pc` equals the saved program counter, and `sr_out` equals the saved status word.
- R9: When `rte_strobe` and `irq_req` are both 1 in the same cycle, the return is performed and the request is dropped; `evt_code` is unchanged.
- R10: A return leaves `saved_r15` unchanged. The block has no output that writes the stack-pointer register.
- R11: When `base_wr_en`=1, `vec_base` loads `base_wr_data` at the edge. An entry accepted in that same cycle uses the old base.
- R12: `redir_valid` is 1 for exactly one cycle per event. With no request and no return pending it reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | 1 | Interrupt request already arbitrated |
| irq_is_reset | input | 1 | The request is a reset-class event |
| irq_code | input | 14 | Event code to record |
| rte_strobe | input | 1 | Return-from-exception strobe |
| live_pc | input | 32 | Current program counter |
| live_sr | input | 32 | Current status word |
| live_r15 | input | 32 | Current stack-pointer register |
| base_wr_en | input | 1 | Write enable for the vector base |
| base_wr_data | input | 32 | Value to load into the vector base |
| redir_valid | output | 1 | One-cycle redirect pulse |
| redir_pc | output | 32 | Redirect target: the handler address or the saved PC |
| sr_out | output | 32 | Status word to load with the redirect |
| evt_code | output | 32 | Recorded event code, upper bits zero |
| saved_r15 | output | 32 | Shadow of the stack-pointer register |
| vec_base | output | 32 | Current vector base |

## Verification
The tests start with a plain interrupt whose status word has bit 15 set and bit 28 clear. This separates the forced mode bits from the bits that pass through. The same request is then repeated with bit 28 set, which shows whether gating by the block bit works. A reset-class event arrives while bit 28 is set, which shows both the bypass of that gate and the clearing of bit 15.

A base write made in the same cycle as an entry, followed by a second entry, separates the old base from the new one. A return issued alone, and a return issued together with a request, show the restore path, the priority of the return, and that the stack-pointer shadow is left alone.

// File: rtl/irq_seq_pkg.sv
// Package: shared constants for the interrupt entry/return sequencer.
// Assumes a 32-bit status word with the control-bit positions listed below.
package irq_seq_pkg;
    localparam int unsigned XLEN       = 32;
    localparam int unsigned CODE_W     = 14;
    localparam int unsigned SR_MODE    = 30;   // supervisor mode bit
    localparam int unsigned SR_BANK    = 29;   // alternate register bank bit
    localparam int unsigned SR_BLOCK   = 28;   // event block bit
    localparam int unsigned SR_FPOFF   = 15;   // floating-point disable bit
    localparam logic [XLEN-1:0] VEC_OFFSET = 32'h0000_0600;

    typedef enum logic [1:0] {
        EV_NONE  = 2'd0,
        EV_ENTRY = 2'd1,
        EV_RET   = 2'd2
    } ev_kind_t;
endpackage

// File: rtl/irq_vec_base.sv
// Module: holds the programmable vector base and forms the handler address.
// Assumes a software write takes effect at the edge where it is sampled.
module irq_vec_base #(
    parameter int unsigned W = 32,
    parameter logic [W-1:0] OFFSET = 32'h600
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wr_data,
    output logic [W-1:0] base_q,
    output logic [W-1:0] vec_addr
);
    // Purpose: base register with a synchronous reset and a write port
    always_ff @(posedge clk) begin
        if (!rst_n)     base_q <= '0;
        else if (wr_en) base_q <= wr_data;
    end

    // Purpose: handler address is the base plus the fixed offset
    always_comb vec_addr = base_q + OFFSET;

    // R11
    base_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> base_q == $past(wr_data));
endmodule

// File: rtl/irq_sr_update.sv
// Module: combinational status-word rewrite applied on exception entry.
// Assumes the bit positions come from the package; all other bits pass through.
module irq_sr_update
    import irq_seq_pkg::*;
#(
    parameter int unsigned W = XLEN
) (
    input  logic [W-1:0] sr_in,
    input  logic         is_reset,
    output logic [W-1:0] sr_entry
);
    // Purpose: force the mode, bank and block bits; clear FP-disable only on reset
    always_comb begin
        sr_entry           = sr_in;
        sr_entry[SR_MODE]  = 1'b1;
        sr_entry[SR_BANK]  = 1'b1;
        sr_entry[SR_BLOCK] = 1'b1;
        if (is_reset) sr_entry[SR_FPOFF] = 1'b0;
    end
endmodule

// File: rtl/irq_shadow_bank.sv
// Module: shadow registers for PC, status word and stack pointer, plus the event code.
// Assumes save_en is asserted only for an accepted entry; all registers load together.
module irq_shadow_bank #(
    parameter int unsigned W  = 32,
    parameter int unsigned CW = 14
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          save_en,
    input  logic [W-1:0]  pc_in,
    input  logic [W-1:0]  sr_in,
    input  logic [W-1:0]  r15_in,
    input  logic [CW-1:0] code_in,
    output logic [W-1:0]  spc_q,
    output logic [W-1:0]  ssr_q,
    output logic [W-1:0]  sgr_q,
    output logic [W-1:0]  evt_q
);
    localparam int unsigned PAD_W = W - CW;

    logic [CW-1:0] code_q;

    // Purpose: capture every shadow in the same cycle as an accepted entry
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            spc_q  <= '0;
            ssr_q  <= '0;
            sgr_q  <= '0;
            code_q <= '0;
        end else if (save_en) begin
            spc_q  <= pc_in;
            ssr_q  <= sr_in;
            sgr_q  <= r15_in;
            code_q <= code_in;
        end
    end

    // Purpose: zero-extend the recorded code to the register width
    always_comb evt_q = {{PAD_W{1'b0}}, code_q};

    // R5
    code_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
        save_en |=> evt_q[CW-1:0] == $past(code_in));
    // R6
    r15_save_chk: assert property (@(posedge clk) disable iff (!rst_n)
        save_en |=> sgr_q == $past(r15_in));
endmodule

// File: rtl/irq_seq_ctrl.sv
// Module: decides entry or return each cycle and registers the redirect outputs.
// Assumes a return has priority over a request arriving in the same cycle.
module irq_seq_ctrl
    import irq_seq_pkg::*;
#(
    parameter int unsigned W = XLEN
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         irq_req,
    input  logic         irq_is_reset,
    input  logic         rte_strobe,
    input  logic         sr_block,
    input  logic [W-1:0] vec_addr,
    input  logic [W-1:0] sr_entry,
    input  logic [W-1:0] spc_q,
    input  logic [W-1:0] ssr_q,
    output logic         accept_entry,
    output logic         redir_valid,
    output logic [W-1:0] redir_pc,
    output logic [W-1:0] sr_out
);
    ev_kind_t ev;

    // Purpose: classify this cycle's event, with return winning over entry
    always_comb begin
        if (rte_strobe)                              ev = EV_RET;
        else if (irq_req && (irq_is_reset || !sr_block)) ev = EV_ENTRY;
        else                                         ev = EV_NONE;
        accept_entry = (ev == EV_ENTRY);
    end

    // Purpose: register the redirect pulse, target and status word
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            redir_valid <= 1'b0;
            redir_pc    <= '0;
            sr_out      <= '0;
        end else begin
            unique case (ev)
                EV_ENTRY: begin
                    redir_valid <= 1'b1;
                    redir_pc    <= vec_addr;
                    sr_out      <= sr_entry;
                end
                EV_RET: begin
                    redir_valid <= 1'b1;
                    redir_pc    <= spc_q;
                    sr_out      <= ssr_q;
                end
                default: redir_valid <= 1'b0;
            endcase
        end
    end

    // R2
    entry_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !rte_strobe && !sr_block) |=> (redir_valid && redir_pc == $past(vec_addr)));
    // R3
    entry_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && !rte_strobe && !sr_block) |=> (sr_out[SR_MODE] && sr_out[SR_BANK] && sr_out[SR_BLOCK]));
    // R7
    blocked_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && sr_block && !irq_is_reset && !rte_strobe) |=> !redir_valid);
    // R12
    pulse_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!irq_req && !rte_strobe) |=> !redir_valid);
endmodule

// File: rtl/irq_entry_seq.sv
// Module: top of the interrupt entry/return sequencer.
// Assumes arbitration and level masking happen upstream; R15 is saved but never restored.
module irq_entry_seq
    import irq_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              irq_req,
    input  logic              irq_is_reset,
    input  logic [CODE_W-1:0] irq_code,
    input  logic              rte_strobe,
    input  logic [XLEN-1:0]   live_pc,
    input  logic [XLEN-1:0]   live_sr,
    input  logic [XLEN-1:0]   live_r15,
    input  logic              base_wr_en,
    input  logic [XLEN-1:0]   base_wr_data,
    output logic              redir_valid,
    output logic [XLEN-1:0]   redir_pc,
    output logic [XLEN-1:0]   sr_out,
    output logic [XLEN-1:0]   evt_code,
    output logic [XLEN-1:0]   saved_r15,
    output logic [XLEN-1:0]   vec_base
);
    logic [XLEN-1:0] vec_addr;
    logic [XLEN-1:0] sr_entry;
    logic [XLEN-1:0] spc_q;
    logic [XLEN-1:0] ssr_q;
    logic            accept_entry;

    irq_vec_base #(.W(XLEN), .OFFSET(VEC_OFFSET)) u_base (
        .clk(clk), .rst_n(rst_n), .wr_en(base_wr_en), .wr_data(base_wr_data),
        .base_q(vec_base), .vec_addr(vec_addr)
    );

    irq_sr_update #(.W(XLEN)) u_srupd (
        .sr_in(live_sr), .is_reset(irq_is_reset), .sr_entry(sr_entry)
    );

    irq_shadow_bank #(.W(XLEN), .CW(CODE_W)) u_shadow (
        .clk(clk), .rst_n(rst_n), .save_en(accept_entry),
        .pc_in(live_pc), .sr_in(live_sr), .r15_in(live_r15), .code_in(irq_code),
        .spc_q(spc_q), .ssr_q(ssr_q), .sgr_q(saved_r15), .evt_q(evt_code)
    );

    irq_seq_ctrl #(.W(XLEN)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_is_reset(irq_is_reset),
        .rte_strobe(rte_strobe), .sr_block(live_sr[SR_BLOCK]), .vec_addr(vec_addr),
        .sr_entry(sr_entry), .spc_q(spc_q), .ssr_q(ssr_q),
        .accept_entry(accept_entry), .redir_valid(redir_valid),
        .redir_pc(redir_pc), .sr_out(sr_out)
    );

    // R8
    ret_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rte_strobe |=> (redir_valid && redir_pc == $past(spc_q) && sr_out == $past(ssr_q)));
    // R9
    ret_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rte_strobe && irq_req) |=> $stable(evt_code));
    // R10
    r15_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rte_strobe |=> $stable(saved_r15));
    // R4
    reset_fp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req && irq_is_reset && !rte_strobe) |=> (redir_valid && !sr_out[SR_FPOFF]));
endmodule

// File: tb/sim_irq_entry_seq.sv
// Directed bench for irq_entry_seq: one task per scenario, each checking its own results.
module sim_irq_entry_seq;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_req = 1'b0;
    logic        irq_is_reset = 1'b0;
    logic [13:0] irq_code = '0;
    logic        rte_strobe = 1'b0;
    logic [31:0] live_pc = '0;
    logic [31:0] live_sr = '0;
    logic [31:0] live_r15 = '0;
    logic        base_wr_en = 1'b0;
    logic [31:0] base_wr_data = '0;
    logic        redir_valid;
    logic [31:0] redir_pc, sr_out, evt_code, saved_r15, vec_base;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_entry_seq u0 (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_is_reset(irq_is_reset),
        .irq_code(irq_code), .rte_strobe(rte_strobe), .live_pc(live_pc),
        .live_sr(live_sr), .live_r15(live_r15), .base_wr_en(base_wr_en),
        .base_wr_data(base_wr_data), .redir_valid(redir_valid), .redir_pc(redir_pc),
        .sr_out(sr_out), .evt_code(evt_code), .saved_r15(saved_r15), .vec_base(vec_base)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // one clock: inputs were set at a falling edge, sample at the next falling edge
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        irq_req = 0; irq_is_reset = 0; rte_strobe = 0; base_wr_en = 0;
    endtask

    task automatic t_reset();
        chk("R1 redir_valid", {31'b0, redir_valid}, 32'h0);
        chk("R1 redir_pc", redir_pc, 32'h0);
        chk("R1 sr_out", sr_out, 32'h0);
        chk("R1 evt_code", evt_code, 32'h0);
        chk("R1 saved_r15", saved_r15, 32'h0);
        chk("R1 vec_base", vec_base, 32'h0);
    endtask

    task automatic t_entry();
        live_pc = 32'h0000_1000; live_sr = 32'h0000_80F0; live_r15 = 32'hCAFE_0000;
        irq_code = 14'h1A5; irq_req = 1;
        step(); idle();
        chk("R2 valid", {31'b0, redir_valid}, 32'h1);
        chk("R2 vector", redir_pc, 32'h0000_0600);
        chk("R3 sr", sr_out, 32'h7000_80F0);
        chk("R5 code", evt_code, 32'h0000_01A5);
        chk("R6 r15", saved_r15, 32'hCAFE_0000);
        step();
        chk("R12 pulse ends", {31'b0, redir_valid}, 32'h0);
    endtask

    task automatic t_blocked();
        live_sr = 32'h1000_0000; live_r15 = 32'h0000_1111; irq_code = 14'h0222; irq_req = 1;
        step(); idle();
        chk("R7 no redirect", {31'b0, redir_valid}, 32'h0);
        chk("R7 code kept", evt_code, 32'h0000_01A5);
        chk("R7 r15 kept", saved_r15, 32'hCAFE_0000);
    endtask

    task automatic t_base();
        live_pc = 32'h0000_2000; live_sr = 32'h0000_0003; live_r15 = 32'h0000_0055;
        irq_code = 14'h3FFF; irq_req = 1;
        base_wr_en = 1; base_wr_data = 32'h8000_0000;
        step(); idle();
        chk("R11 old base used", redir_pc, 32'h0000_0600);
        chk("R11 base loaded", vec_base, 32'h8000_0000);
        chk("R5 full code", evt_code, 32'h0000_3FFF);
        chk("R3 low bits", sr_out, 32'h7000_0003);
        live_pc = 32'h0000_3000; live_sr = 32'h0000_0004; live_r15 = 32'h0000_0077;
        irq_code = 14'h0010; irq_req = 1;
        step(); idle();
        chk("R11 new base used", redir_pc, 32'h8000_0600);
    endtask

    task automatic t_return();
        live_sr = 32'h7000_0004; rte_strobe = 1;
        step(); idle();
        chk("R8 valid", {31'b0, redir_valid}, 32'h1);
        chk("R8 pc", redir_pc, 32'h0000_3000);
        chk("R8 sr", sr_out, 32'h0000_0004);
        chk("R10 r15 kept", saved_r15, 32'h0000_0077);
    endtask

    task automatic t_ret_vs_irq();
        live_pc = 32'h0000_4000; live_sr = 32'h0000_8000; live_r15 = 32'h0000_0099;
        irq_code = 14'h0020; irq_req = 1;
        step(); idle();
        chk("R3 bit15 kept", sr_out, 32'h7000_8000);
        live_pc = 32'h0000_4444; live_sr = 32'h0; live_r15 = 32'h0000_0AAA;
        irq_code = 14'h0030; irq_req = 1; rte_strobe = 1;
        step(); idle();
        chk("R9 return pc", redir_pc, 32'h0000_4000);
        chk("R9 return sr", sr_out, 32'h0000_8000);
        chk("R9 code kept", evt_code, 32'h0000_0020);
        chk("R9 r15 kept", saved_r15, 32'h0000_0099);
    endtask

    task automatic t_reset_event();
        live_pc = 32'h0000_5000; live_sr = 32'h1000_8001; live_r15 = 32'h0000_00AB;
        irq_code = 14'h0; irq_req = 1; irq_is_reset = 1;
        step(); idle();
        chk("R4 accepted", {31'b0, redir_valid}, 32'h1);
        chk("R4 pc", redir_pc, 32'h8000_0600);
        chk("R4 fp cleared", sr_out, 32'h7000_0001);
        chk("R4 code", evt_code, 32'h0);
        rte_strobe = 1;
        step(); idle();
        chk("R6 saved pc", redir_pc, 32'h0000_5000);
        chk("R6 saved sr", sr_out, 32'h1000_8001);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_entry();
        t_blocked();
        t_base();
        t_return();
        t_ret_vs_irq();
        t_reset_event();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule